// File: doc/BRIEF.md
# Counter Enable Register with Access Screening

This block holds the enable bits for a bank of up to sixteen auxiliary event counters and presents them as a 32-bit system register. Software reaches the register through a coprocessor-style request port that carries a five-field selector, a read/write flag and write data. A write uses write-one-to-set semantics. Ones turn counters on, and zeros leave them as they are. A second, clear-type view of the same state comes in through a separate mask port. The live enable vector drives the counters directly and also serves as the read-back of that clear view.

Every request that matches the selector is screened before it touches state. A fixed-priority permission chain looks at the requester's privilege level (0 to 3) and at several inputs. These are trap controls owned by levels 2 and 3, a user-access enable, a routing bit that diverts level-0 faults to level 2, a fine-grained trap bit with its level-3 gate, and the number of implemented counter groups. The chain settles on one verdict: perform the access, report it as undefined, or trap it to a target level with a syndrome. The verdict comes back one clock after the request, and read data travels with it.

Top module: `cnt_enable_csr`

## Requirements
- R1: On active-low reset, all enable bits are 0 and no response is valid.
- R2: A request is recognised only when coprocessor=15, opc1=0, CRn=13, CRm=3 and opc2=1. Any other selector gives no response (rsp_valid stays 0) and leaves the enables unchanged.
- R3: A performed write sets every enable bit n whose write-data bit n is 1. Bits written with 0 keep their value.
- R4: Write-data bits 31:16 have no effect, and read data bits 31:16 are always 0.
- R5: The clear port clears every enable bit whose mask bit is 1. When a performed set and a clear hit the same bit in the same cycle, the set wins. Enables changed on either path are seen through both views.
- R6: The response is registered. It is valid in the cycle after the request and has exactly one of perform, undefined or trap set. A performed read returns the enable vector as it was before that edge. Target and syndrome are 0 unless the response is a trap, and every trap carries syndrome 0x03.
- R7: When the implemented group count is 0, every recognised read or write is undefined and changes no state.
- R8: A write performs only at level 3, the highest level. At level 1 with the level-2 system-register trap set, it traps to level 2. In every other case it is undefined.
- R9: A read at level 3 always performs, whatever the trap controls say.
- R10: A read at level 2 with the level-3 monitor trap set traps to level 3 when the undefined-select input is 0 and is undefined when it is 1. Otherwise it performs, and level-2 trap controls do not affect it.
- R11: A read at level 1 checks, in order, the level-2 system-register trap, then the level-2 monitor trap (each traps to level 2), then the level-3 monitor trap (as in R10). If none is set, it performs.
- R12: A read at level 0 with user access disabled traps to level 2 when the routing bit is 1 and to level 1 when it is 0. This check comes before every other level-0 trap check.
- R13: A read at level 0 with the fine-grained trap bit set traps to level 2 only when the fine-grained enable from level 3 is 1. This check comes after the level-2 traps and before the level-3 monitor trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_coproc | input | 4 | Selector: coprocessor number |
| req_opc1 | input | 3 | Selector: first opcode field |
| req_crn | input | 4 | Selector: primary register field |
| req_crm | input | 4 | Selector: secondary register field |
| req_opc2 | input | 3 | Selector: second opcode field |
| req_wdata | input | 32 | Write data (ones set enables) |
| cur_level | input | 2 | Privilege level of the requester |
| group_count | input | 4 | Implemented counter groups; 0 makes every access undefined |
| user_acc_en | input | 1 | Level-0 access permitted |
| l2_route_user | input | 1 | Send level-0 user-access faults to level 2 |
| l2_sysreg_trap | input | 1 | Level-2 trap on this register group |
| l2_monitor_trap | input | 1 | Level-2 trap on monitor registers |
| l3_monitor_trap | input | 1 | Level-3 trap on monitor registers |
| l3_undef_sel | input | 1 | Turn level-3 monitor traps into undefined |
| fg_trap | input | 1 | Fine-grained read trap for this register |
| fg_enable | input | 1 | Level-3 enable for fine-grained traps |
| clr_we | input | 1 | Clear-view write strobe |
| clr_mask | input | 16 | Clear-view mask (ones clear enables) |
| rsp_valid | output | 1 | Response valid |
| rsp_perform | output | 1 | Access was performed |
| rsp_undef | output | 1 | Access is undefined |
| rsp_trap | output | 1 | Access traps |
| rsp_target | output | 2 | Trap target level |
| rsp_syndrome | output | 6 | Trap syndrome |
| rsp_rdata | output | 32 | Read data |
| cnt_enable | output | 16 | Enable vector to the counters |

## Verification
The bench sets several trap controls at once so that priority mistakes show up. At level 1 with all three traps set, a chain with the wrong order would send the read to level 3 instead of level 2. At level 0 with user access off, a checker that tests the level-3 trap first would report a level-3 trap or undefined rather than a trap to level 1. It also checks that set wins over clear on the same bit, that writes of zero or of only upper bits leave the enables as they were, and that a wrong selector produces no response at all. It checks that a group count of zero overrides even a level-3 access, which a design that tested privilege first would perform.

// File: rtl/cnten_pkg.sv
package cnten_pkg;

  typedef enum logic [1:0] {
    V_DO    = 2'd0,
    V_UNDEF = 2'd1,
    V_TRAP  = 2'd2
  } verdict_e;

  typedef struct packed {
    verdict_e    kind;
    logic [1:0]  target;
    logic [5:0]  syndrome;
  } outcome_t;

  localparam logic [5:0] SYN_SYSACC = 6'h03;

  function automatic outcome_t oc_do();
    outcome_t o;
    o.kind = V_DO; o.target = 2'd0; o.syndrome = 6'h00;
    return o;
  endfunction

  function automatic outcome_t oc_undef();
    outcome_t o;
    o.kind = V_UNDEF; o.target = 2'd0; o.syndrome = 6'h00;
    return o;
  endfunction

  function automatic outcome_t oc_trap(input logic [1:0] lvl);
    outcome_t o;
    o.kind = V_TRAP; o.target = lvl; o.syndrome = SYN_SYSACC;
    return o;
  endfunction

  // Next state of one enable bit: a set beats a clear.
  function automatic logic next_bit(input logic cur, input logic set_b, input logic clr_b);
    return set_b | (cur & ~clr_b);
  endfunction

endpackage

// File: rtl/sel_match.sv
module sel_match #(
  parameter int COPROC = 15,
  parameter int OPC1   = 0,
  parameter int CRN    = 13,
  parameter int CRM    = 3,
  parameter int OPC2   = 1
) (
  input  logic [3:0] coproc,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  output logic       hit
);
  assign hit = (coproc == 4'(COPROC)) && (opc1 == 3'(OPC1)) &&
               (crn == 4'(CRN)) && (crm == 4'(CRM)) && (opc2 == 3'(OPC2));
endmodule

// File: rtl/access_arbiter.sv
module access_arbiter
  import cnten_pkg::*;
#(
  parameter int TOP_LEVEL = 3
) (
  input  logic       is_write,
  input  logic [1:0] level,
  input  logic       no_groups,
  input  logic       user_acc_en,
  input  logic       l2_route_user,
  input  logic       l2_sysreg_trap,
  input  logic       l2_monitor_trap,
  input  logic       l3_monitor_trap,
  input  logic       l3_undef_sel,
  input  logic       fg_trap,
  input  logic       fg_enable,
  output outcome_t   verdict
);
  localparam logic [1:0] TOP_LVL = 2'(TOP_LEVEL);
  localparam bit HAS_L2 = (TOP_LEVEL >= 2);
  localparam bit HAS_L3 = (TOP_LEVEL == 3);

  logic     l2_sys_hit, l2_mon_hit, l3_hit, fg_hit;
  outcome_t l3_result;

  assign l2_sys_hit = HAS_L2 && l2_sysreg_trap;
  assign l2_mon_hit = HAS_L2 && l2_monitor_trap;
  assign l3_hit     = HAS_L3 && l3_monitor_trap;
  assign fg_hit     = HAS_L2 && fg_trap && (!HAS_L3 || fg_enable);
  assign l3_result  = l3_undef_sel ? oc_undef() : oc_trap(2'd3);

  always_comb begin
    verdict = oc_do();
    if (no_groups) begin
      verdict = oc_undef();
    end else if (is_write) begin
      if (level == 2'd1 && l2_sys_hit) verdict = oc_trap(2'd2);
      else if (level == TOP_LVL)       verdict = oc_do();
      else                             verdict = oc_undef();
    end else begin
      unique case (level)
        2'd3: verdict = HAS_L3 ? oc_do() : oc_undef();
        2'd2: begin
          if (!HAS_L2)     verdict = oc_undef();
          else if (l3_hit) verdict = l3_result;
          else             verdict = oc_do();
        end
        2'd1: begin
          if (l2_sys_hit)      verdict = oc_trap(2'd2);
          else if (l2_mon_hit) verdict = oc_trap(2'd2);
          else if (l3_hit)     verdict = l3_result;
          else                 verdict = oc_do();
        end
        default: begin
          if (!user_acc_en)    verdict = (l2_route_user && HAS_L2) ? oc_trap(2'd2) : oc_trap(2'd1);
          else if (l2_sys_hit) verdict = oc_trap(2'd2);
          else if (l2_mon_hit) verdict = oc_trap(2'd2);
          else if (fg_hit)     verdict = oc_trap(2'd2);
          else if (l3_hit)     verdict = l3_result;
          else                 verdict = oc_do();
        end
      endcase
    end
  end
endmodule

// File: rtl/enable_bits.sv
module enable_bits
  import cnten_pkg::*;
#(
  parameter int NCNT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we,
  input  logic [NCNT-1:0] set_mask,
  input  logic            clr_we,
  input  logic [NCNT-1:0] clr_mask,
  output logic [NCNT-1:0] en_q
);
  logic [NCNT-1:0] set_eff, clr_eff;
  assign set_eff = set_we ? set_mask : '0;
  assign clr_eff = clr_we ? clr_mask : '0;

  for (genvar b = 0; b < NCNT; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= next_bit(bit_q, set_eff[b], clr_eff[b]);
    end
    assign en_q[b] = bit_q;
  end

  logic [NCNT-1:0] collide;
  assign collide = set_eff & clr_eff;

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|collide) |=> ((en_q & $past(collide)) == $past(collide)));

  assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((en_q & $past(clr_mask)) == '0));
endmodule

// File: rtl/cnt_enable_csr.sv
module cnt_enable_csr
  import cnten_pkg::*;
#(
  parameter int NCNT      = 16,
  parameter int REG_W     = 32,
  parameter int GRP_W     = 4,
  parameter int TOP_LEVEL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [3:0]       req_coproc,
  input  logic [2:0]       req_opc1,
  input  logic [3:0]       req_crn,
  input  logic [3:0]       req_crm,
  input  logic [2:0]       req_opc2,
  input  logic [REG_W-1:0] req_wdata,
  input  logic [1:0]       cur_level,
  input  logic [GRP_W-1:0] group_count,
  input  logic             user_acc_en,
  input  logic             l2_route_user,
  input  logic             l2_sysreg_trap,
  input  logic             l2_monitor_trap,
  input  logic             l3_monitor_trap,
  input  logic             l3_undef_sel,
  input  logic             fg_trap,
  input  logic             fg_enable,
  input  logic             clr_we,
  input  logic [NCNT-1:0]  clr_mask,
  output logic             rsp_valid,
  output logic             rsp_perform,
  output logic             rsp_undef,
  output logic             rsp_trap,
  output logic [1:0]       rsp_target,
  output logic [5:0]       rsp_syndrome,
  output logic [REG_W-1:0] rsp_rdata,
  output logic [NCNT-1:0]  cnt_enable
);
  localparam logic [1:0] TOP_LVL = 2'(TOP_LEVEL);

  logic     sel_hit, req_hit, no_groups, perform_now, set_we;
  outcome_t verdict;

  sel_match u_sel (
    .coproc(req_coproc), .opc1(req_opc1), .crn(req_crn),
    .crm(req_crm), .opc2(req_opc2), .hit(sel_hit)
  );

  assign req_hit   = req_valid && sel_hit;
  assign no_groups = (group_count == '0);

  access_arbiter #(.TOP_LEVEL(TOP_LEVEL)) u_arb (
    .is_write(req_write), .level(cur_level), .no_groups(no_groups),
    .user_acc_en(user_acc_en), .l2_route_user(l2_route_user),
    .l2_sysreg_trap(l2_sysreg_trap), .l2_monitor_trap(l2_monitor_trap),
    .l3_monitor_trap(l3_monitor_trap), .l3_undef_sel(l3_undef_sel),
    .fg_trap(fg_trap), .fg_enable(fg_enable), .verdict(verdict)
  );

  assign perform_now = req_hit && (verdict.kind == V_DO);
  assign set_we      = perform_now && req_write;

  enable_bits #(.NCNT(NCNT)) u_bits (
    .clk(clk), .rst_n(rst_n), .set_we(set_we),
    .set_mask(req_wdata[NCNT-1:0]), .clr_we(clr_we),
    .clr_mask(clr_mask), .en_q(cnt_enable)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_perform  <= 1'b0;
      rsp_undef    <= 1'b0;
      rsp_trap     <= 1'b0;
      rsp_target   <= 2'd0;
      rsp_syndrome <= 6'd0;
      rsp_rdata    <= '0;
    end else begin
      rsp_valid    <= req_hit;
      rsp_perform  <= perform_now;
      rsp_undef    <= req_hit && (verdict.kind == V_UNDEF);
      rsp_trap     <= req_hit && (verdict.kind == V_TRAP);
      rsp_target   <= req_hit ? verdict.target : 2'd0;
      rsp_syndrome <= req_hit ? verdict.syndrome : 6'd0;
      rsp_rdata    <= (perform_now && !req_write) ? REG_W'(cnt_enable) : '0;
    end
  end

  assert_one_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_perform, rsp_undef, rsp_trap}));

  assert_trap_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_target != 2'd0 && rsp_syndrome == 6'h03));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rdata >> NCNT) == '0);

  assert_no_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_hit |=> !rsp_valid);

  assert_no_groups_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && no_groups) |=> rsp_undef);

  assert_write_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && req_write && cur_level != TOP_LVL && cur_level != 2'd1) |=> rsp_undef);

  assert_top_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && !req_write && cur_level == TOP_LVL && !no_groups) |=> rsp_perform);

  assert_zero_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((cnt_enable & $past(cnt_enable)) == $past(cnt_enable)));
endmodule

// File: tb/sim_cnt_enable_csr.sv
module sim_cnt_enable_csr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0;
  logic [3:0]  req_coproc = 4'd15, req_crn = 4'd13, req_crm = 4'd3;
  logic [2:0]  req_opc1 = 3'd0, req_opc2 = 3'd1;
  logic [31:0] req_wdata = '0;
  logic [1:0]  cur_level = 2'd3;
  logic [3:0]  group_count = 4'd1;
  logic        user_acc_en = 1, l2_route_user = 0, l2_sysreg_trap = 0;
  logic        l2_monitor_trap = 0, l3_monitor_trap = 0, l3_undef_sel = 0;
  logic        fg_trap = 0, fg_enable = 0, clr_we = 0;
  logic [15:0] clr_mask = '0;
  logic        rsp_valid, rsp_perform, rsp_undef, rsp_trap;
  logic [1:0]  rsp_target;
  logic [5:0]  rsp_syndrome;
  logic [31:0] rsp_rdata;
  logic [15:0] cnt_enable;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnt_enable_csr u0 (.*);

  // Packed response: {valid, perform, undef, trap, target, syndrome}
  localparam logic [11:0] R_DO    = {1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 6'h00};
  localparam logic [11:0] R_UNDEF = {1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 6'h00};
  localparam logic [11:0] R_NONE  = 12'd0;
  function automatic logic [11:0] r_trap(input logic [1:0] l);
    return {1'b1, 1'b0, 1'b0, 1'b1, l, 6'h03};
  endfunction

  function automatic logic [11:0] rsp_now();
    return {rsp_valid, rsp_perform, rsp_undef, rsp_trap, rsp_target, rsp_syndrome};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic controls_clear();
    group_count = 4'd1; user_acc_en = 1; l2_route_user = 0; l2_sysreg_trap = 0;
    l2_monitor_trap = 0; l3_monitor_trap = 0; l3_undef_sel = 0;
    fg_trap = 0; fg_enable = 0; clr_we = 0; clr_mask = '0;
  endtask

  // Drive one request at a negedge; sample the registered response one negedge later.
  task automatic access(input logic wr, input logic [1:0] lvl, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; cur_level = lvl; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_wdata = '0;
  endtask

  task automatic t_reset();
    check("R1 enables", 64'(cnt_enable), 64'h0);
    check("R1 rsp_valid", 64'(rsp_valid), 64'h0);
  endtask

  task automatic t_set();
    controls_clear();
    access(1, 2'd3, 32'h0000_0005);
    check("R3 write performs", 64'(rsp_now()), 64'(R_DO));
    check("R3 bits set", 64'(cnt_enable), 64'h0005);
    access(1, 2'd3, 32'h0000_0100);
    check("R3 zeros keep", 64'(cnt_enable), 64'h0105);
    access(0, 2'd3, 32'h0);
    check("R6 read data", 64'(rsp_rdata), 64'h0105);
    check("R6 read perform", 64'(rsp_now()), 64'(R_DO));
  endtask

  task automatic t_upper();
    access(1, 2'd3, 32'hFFFF_0000);
    check("R4 upper write ignored", 64'(cnt_enable), 64'h0105);
    access(0, 2'd3, 32'h0);
    check("R4 upper read zero", 64'(rsp_rdata), 64'h0000_0105);
  endtask

  task automatic t_decode();
    req_crm = 4'd2;
    access(1, 2'd3, 32'h0000_FFFF);
    check("R2 wrong CRm no rsp", 64'(rsp_now()), 64'(R_NONE));
    check("R2 wrong CRm no write", 64'(cnt_enable), 64'h0105);
    req_crm = 4'd3; req_opc2 = 3'd0;
    access(1, 2'd3, 32'h0000_FFFF);
    check("R2 wrong opc2 no rsp", 64'(rsp_valid), 64'h0);
    check("R2 wrong opc2 no write", 64'(cnt_enable), 64'h0105);
    req_opc2 = 3'd1;
  endtask

  task automatic t_clear();
    @(negedge clk);
    clr_we = 1; clr_mask = 16'h0001;
    @(negedge clk);
    clr_we = 0; clr_mask = '0;
    check("R5 clear port", 64'(cnt_enable), 64'h0104);
    @(negedge clk);
    clr_we = 1; clr_mask = 16'h0014;
    req_valid = 1; req_write = 1; cur_level = 2'd3; req_wdata = 32'h0000_0014;
    @(negedge clk);
    req_valid = 0; req_write = 0; clr_we = 0; clr_mask = '0;
    check("R5 set wins", 64'(cnt_enable), 64'h0114);
    access(0, 2'd3, 32'h0);
    check("R5 shared view read", 64'(rsp_rdata), 64'h0114);
  endtask

  task automatic t_nogroup();
    controls_clear();
    group_count = 4'd0;
    access(0, 2'd3, 32'h0);
    check("R7 read undef", 64'(rsp_now()), 64'(R_UNDEF));
    check("R7 no read data", 64'(rsp_rdata), 64'h0);
    access(1, 2'd3, 32'h0000_FFFF);
    check("R7 write undef", 64'(rsp_now()), 64'(R_UNDEF));
    check("R7 write no effect", 64'(cnt_enable), 64'h0114);
    group_count = 4'd1;
  endtask

  task automatic t_write_levels();
    controls_clear();
    l2_sysreg_trap = 1;
    access(1, 2'd1, 32'h0000_8000);
    check("R8 L1 write trap L2", 64'(rsp_now()), 64'(r_trap(2'd2)));
    check("R8 trapped write no effect", 64'(cnt_enable), 64'h0114);
    l2_sysreg_trap = 0;
    access(1, 2'd1, 32'h0000_8000);
    check("R8 L1 write undef", 64'(rsp_now()), 64'(R_UNDEF));
    l2_sysreg_trap = 1;
    access(1, 2'd2, 32'h0000_8000);
    check("R8 L2 write undef", 64'(rsp_now()), 64'(R_UNDEF));
    access(1, 2'd0, 32'h0000_8000);
    check("R8 L0 write undef", 64'(rsp_now()), 64'(R_UNDEF));
    check("R8 undef writes no effect", 64'(cnt_enable), 64'h0114);
  endtask

  task automatic t_read_l3();
    controls_clear();
    user_acc_en = 0; l2_sysreg_trap = 1; l2_monitor_trap = 1; l3_monitor_trap = 1;
    fg_trap = 1; fg_enable = 1;
    access(0, 2'd3, 32'h0);
    check("R9 L3 read performs", 64'(rsp_now()), 64'(R_DO));
  endtask

  task automatic t_read_l2();
    controls_clear();
    l3_monitor_trap = 1;
    access(0, 2'd2, 32'h0);
    check("R10 L2 trap L3", 64'(rsp_now()), 64'(r_trap(2'd3)));
    l3_undef_sel = 1;
    access(0, 2'd2, 32'h0);
    check("R10 L2 undef select", 64'(rsp_now()), 64'(R_UNDEF));
    controls_clear();
    l2_sysreg_trap = 1; l2_monitor_trap = 1;
    access(0, 2'd2, 32'h0);
    check("R10 L2 ignores L2 traps", 64'(rsp_now()), 64'(R_DO));
    check("R10 L2 read data", 64'(rsp_rdata), 64'h0114);
  endtask

  task automatic t_read_l1();
    controls_clear();
    l2_sysreg_trap = 1; l2_monitor_trap = 1; l3_monitor_trap = 1;
    access(0, 2'd1, 32'h0);
    check("R11 sysreg trap first", 64'(rsp_now()), 64'(r_trap(2'd2)));
    l2_sysreg_trap = 0;
    access(0, 2'd1, 32'h0);
    check("R11 monitor trap before L3", 64'(rsp_now()), 64'(r_trap(2'd2)));
    l2_monitor_trap = 0;
    access(0, 2'd1, 32'h0);
    check("R11 L3 trap last", 64'(rsp_now()), 64'(r_trap(2'd3)));
    l3_monitor_trap = 0;
    access(0, 2'd1, 32'h0);
    check("R11 L1 performs", 64'(rsp_now()), 64'(R_DO));
  endtask

  task automatic t_read_l0();
    controls_clear();
    user_acc_en = 0; l3_monitor_trap = 1; l3_undef_sel = 1; l2_sysreg_trap = 1;
    access(0, 2'd0, 32'h0);
    check("R12 user off to L1", 64'(rsp_now()), 64'(r_trap(2'd1)));
    l2_route_user = 1;
    access(0, 2'd0, 32'h0);
    check("R12 user off routed L2", 64'(rsp_now()), 64'(r_trap(2'd2)));
    controls_clear();
    fg_trap = 1; fg_enable = 0;
    access(0, 2'd0, 32'h0);
    check("R13 fg gated off", 64'(rsp_now()), 64'(R_DO));
    fg_enable = 1; l3_monitor_trap = 1;
    access(0, 2'd0, 32'h0);
    check("R13 fg trap before L3", 64'(rsp_now()), 64'(r_trap(2'd2)));
    fg_trap = 0;
    access(0, 2'd0, 32'h0);
    check("R13 then L3 trap", 64'(rsp_now()), 64'(r_trap(2'd3)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_set();
    t_upper();
    t_decode();
    t_clear();
    t_nogroup();
    t_write_levels();
    t_read_l3();
    t_read_l2();
    t_read_l1();
    t_read_l0();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule